// File: doc/BRIEF.md
# I2C EEPROM Transaction Classifier

This block is a passive observer on an I2C bus that carries traffic for a serial EEPROM. It does not see SCL or SDA. It receives a stream of bus events that have already been decoded: start, repeated start, stop, address phase with read or write, data byte read, data byte written, ACK and NACK. Each event comes with an 8-bit payload. The block follows the ACK, NACK and restart pattern of each transaction and names the memory operation it carried. It does this through a branching state machine.

When a transaction completes, the block emits one result record. The record holds an operation class, the starting word address, the number of data bytes and a set of warning flags. The block also keeps a shadow copy of the memory's internal address counter, so that a current-address read can report the location it actually returned. Some transactions break off with a warning: the device gives no answer, or the master quits right after the control byte. These produce a record with class "none" and the matching flag.

Top module: `eeprom_op_sorter`

## Requirements
- R1: Reset clears `resValid`, returns the machine to waiting for a start and loads the shadow address counter from `cfgInitAddr`.
- R2: An event that does not follow a start is ignored. So is an event that is not an address phase after a start, and such an event also drops the transaction. Neither produces a result, and neither changes the shadow counter.
- R3: A stop after the word address and exactly one written data byte reports class 1 (byte write) with count 1. With `cfgTwoByteAddr`=1 the address is two bytes, sent high byte first. Otherwise it is one byte and the upper 8 bits read as zero.
- R4: A stop after two or more written data bytes reports class 2 (page write) with the byte count. A stop after fewer than one data byte produces no result.
- R5: A repeated start after the word address, followed by an address-read phase, begins a random read. If one byte is read before the NACK and stop, the class is 4. If two or more bytes are read, the class is 5 (sequential).
- R6: A read-addressed transaction whose first data byte is NACKed and then stopped reports class 3 (current read), count 1, at the shadow counter address. The counter then advances by one.
- R7: After each reported write or random read, the shadow counter equals the word address plus the data count. In one-byte address mode it wraps at 8 bits.
- R8: On a page write, warning bit 2 is set when the count exceeds `PAGE_SIZE`.
- R9: On a page write, warning bit 3 is set when the page number of the first address differs from the page number of the last address. The page number is the address shifted right by log2(`PAGE_SIZE`).
- R10: A NACK on the control byte reports class 0 with warning bit 0. A stop right after an ACKed control byte reports class 0 with warning bit 1. Neither moves the counter.
- R11: A stop that follows an ACKed byte in a random read reports the read with warning bit 4.
- R12: A repeated start where a stop was expected reports the operation with warning bit 5. The next event is then taken at once as a new control byte.
- R13: `resValid` is a single-cycle pulse, registered in the cycle after the event that completes the transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evtValid | input | 1 | Event present this cycle |
| evtKind | input | 4 | Event code: 1 start, 2 repeated start, 3 stop, 4 address-read, 5 address-write, 6 data read, 7 data written, 8 ACK, 9 NACK |
| evtData | input | 8 | Payload byte of the event |
| cfgTwoByteAddr | input | 1 | 1: two-byte word address, 0: one byte |
| cfgInitAddr | input | 16 | Shadow counter value loaded at reset |
| resValid | output | 1 | Result pulse |
| resClass | output | 3 | 0 none, 1 byte write, 2 page write, 3 current read, 4 random read, 5 sequential read |
| resAddr | output | 16 | Start address of the operation |
| resCount | output | 8 | Number of data bytes |
| resWarn | output | 6 | Warning flags, bits as in R8 to R12 |

## Verification
Two things can happen on one clock edge. A repeated start that arrives in place of the closing stop must publish the finished record and update the shadow counter. On that same edge it must also wipe the per-transaction address and count, so that a new control byte can follow immediately. The bench provokes this by ending a current-address read with a repeated start and then sending a full byte write with no further start. It judges the result from the flagged read record, the byte-write record that follows, and a later current read that shows where the counter ended up.

// File: rtl/eos_pkg.sv
package eos_pkg;

  typedef enum logic [3:0] {
    EV_NONE    = 4'd0,
    EV_START   = 4'd1,
    EV_RESTART = 4'd2,
    EV_STOP    = 4'd3,
    EV_ADDR_RD = 4'd4,
    EV_ADDR_WR = 4'd5,
    EV_DATA_RD = 4'd6,
    EV_DATA_WR = 4'd7,
    EV_ACK     = 4'd8,
    EV_NACK    = 4'd9
  } evt_e;

  typedef enum logic [2:0] {
    CL_NONE    = 3'd0,
    CL_BYTE_WR = 3'd1,
    CL_PAGE_WR = 3'd2,
    CL_CUR_RD  = 3'd3,
    CL_RAND_RD = 3'd4,
    CL_SEQ_RD  = 3'd5
  } cls_e;

  localparam int WARN_W     = 6;
  localparam int WB_NOREPLY = 0;
  localparam int WB_ABORT   = 1;
  localparam int WB_OVER    = 2;
  localparam int WB_CROSS   = 3;
  localparam int WB_ACKSTOP = 4;
  localparam int WB_RESTART = 5;

  typedef struct packed {
    logic              clear;
    logic              ldHi;
    logic              ldLo;
    logic              incCnt;
    logic              emit;
    cls_e              cls;
    logic [WARN_W-1:0] warn;
  } strobe_t;

endpackage

// File: rtl/eos_ctrl.sv
module eos_ctrl
  import eos_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evtValid,
  input  logic [3:0]       evtKind,
  input  logic             cfgTwoByteAddr,
  input  logic [CNT_W-1:0] dataCnt,
  output strobe_t          strb
);

  typedef enum logic [4:0] {
    S_IDLE, S_CTRL,
    S_R_CACK, S_R_BYTE, S_R_BACK,
    S_W_CACK, S_W_ADDR, S_W_AACK_HI, S_W_ADDR_LO, S_W_AACK_LO,
    S_W_DATA, S_W_DACK,
    S_R2_CTRL, S_R2_CACK, S_R2_BYTE, S_R2_BACK,
    S_END_CUR, S_END_RND
  } state_e;

  state_e state, nxt;
  evt_e   kind;
  logic   cntZero, cntOne;
  cls_e   rndCls;

  assign kind    = evt_e'(evtKind);
  assign cntZero = (dataCnt == '0);
  assign cntOne  = (dataCnt == CNT_W'(1));
  assign rndCls  = cntOne ? CL_RAND_RD : CL_SEQ_RD;

  always_comb begin
    nxt  = state;
    strb = '0;
    if (evtValid) begin
      case (state)
        S_IDLE: begin
          if (kind == EV_START || kind == EV_RESTART) begin
            strb.clear = 1'b1;
            nxt = S_CTRL;
          end
        end
        S_CTRL: begin
          if (kind == EV_ADDR_RD)      nxt = S_R_CACK;
          else if (kind == EV_ADDR_WR) nxt = S_W_CACK;
          else                         nxt = S_IDLE;
        end
        S_R_CACK, S_W_CACK: begin
          if (kind == EV_ACK) begin
            nxt = (state == S_R_CACK) ? S_R_BYTE : S_W_ADDR;
          end else begin
            nxt = S_IDLE;
            if (kind == EV_NACK) begin
              strb.emit = 1'b1;
              strb.cls  = CL_NONE;
              strb.warn[WB_NOREPLY] = 1'b1;
            end
          end
        end
        S_R_BYTE: begin
          if (kind == EV_DATA_RD) begin
            strb.incCnt = 1'b1;
            nxt = S_R_BACK;
          end else begin
            nxt = S_IDLE;
            if (kind == EV_STOP) begin
              strb.emit = 1'b1;
              strb.cls  = CL_NONE;
              strb.warn[WB_ABORT] = 1'b1;
            end
          end
        end
        S_R_BACK: nxt = (kind == EV_NACK) ? S_END_CUR : S_IDLE;
        S_W_ADDR: begin
          if (kind == EV_DATA_WR) begin
            strb.ldHi = cfgTwoByteAddr;
            strb.ldLo = !cfgTwoByteAddr;
            nxt = cfgTwoByteAddr ? S_W_AACK_HI : S_W_AACK_LO;
          end else begin
            nxt = S_IDLE;
            if (kind == EV_STOP) begin
              strb.emit = 1'b1;
              strb.cls  = CL_NONE;
              strb.warn[WB_ABORT] = 1'b1;
            end
          end
        end
        S_W_AACK_HI: nxt = (kind == EV_ACK) ? S_W_ADDR_LO : S_IDLE;
        S_W_ADDR_LO: begin
          if (kind == EV_DATA_WR) begin
            strb.ldLo = 1'b1;
            nxt = S_W_AACK_LO;
          end else begin
            nxt = S_IDLE;
          end
        end
        S_W_AACK_LO: nxt = (kind == EV_ACK) ? S_W_DATA : S_IDLE;
        S_W_DATA: begin
          if (kind == EV_DATA_WR) begin
            strb.incCnt = 1'b1;
            nxt = S_W_DACK;
          end else if (kind == EV_STOP) begin
            nxt = S_IDLE;
            if (!cntZero) begin
              strb.emit = 1'b1;
              strb.cls  = cntOne ? CL_BYTE_WR : CL_PAGE_WR;
            end
          end else if (kind == EV_RESTART && cntZero) begin
            nxt = S_R2_CTRL;
          end else begin
            nxt = S_IDLE;
          end
        end
        S_W_DACK:  nxt = (kind == EV_ACK) ? S_W_DATA : S_IDLE;
        S_R2_CTRL: nxt = (kind == EV_ADDR_RD) ? S_R2_CACK : S_IDLE;
        S_R2_CACK: nxt = (kind == EV_ACK) ? S_R2_BYTE : S_IDLE;
        S_R2_BYTE: begin
          if (kind == EV_DATA_RD) begin
            strb.incCnt = 1'b1;
            nxt = S_R2_BACK;
          end else begin
            nxt = S_IDLE;
            if (kind == EV_STOP && !cntZero) begin
              strb.emit = 1'b1;
              strb.cls  = rndCls;
              strb.warn[WB_ACKSTOP] = 1'b1;
            end
          end
        end
        S_R2_BACK: begin
          if (kind == EV_ACK)       nxt = S_R2_BYTE;
          else if (kind == EV_NACK) nxt = S_END_RND;
          else                      nxt = S_IDLE;
        end
        S_END_CUR, S_END_RND: begin
          nxt = S_IDLE;
          if (kind == EV_STOP || kind == EV_RESTART) begin
            strb.emit = 1'b1;
            strb.cls  = (state == S_END_CUR) ? CL_CUR_RD : rndCls;
            if (kind == EV_RESTART) begin
              strb.warn[WB_RESTART] = 1'b1;
              strb.clear = 1'b1;
              nxt = S_CTRL;
            end
          end
        end
        default: nxt = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= S_IDLE;
    else        state <= nxt;
  end

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !evtValid |=> $stable(state));

  // R13
  emit_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.emit |-> (evtValid && (kind == EV_STOP || kind == EV_RESTART || kind == EV_NACK)));

  // R12
  restart_resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.emit && strb.warn[WB_RESTART]) |=> (state == S_CTRL));

endmodule

// File: rtl/eos_datapath.sv
module eos_datapath
  import eos_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int CNT_W     = 8,
  parameter int PAGE_SIZE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  strobe_t           strb,
  input  logic [7:0]        evtData,
  input  logic              cfgTwoByteAddr,
  input  logic [ADDR_W-1:0] cfgInitAddr,
  output logic [CNT_W-1:0]  dataCnt,
  output logic              resValid,
  output logic [2:0]        resClass,
  output logic [ADDR_W-1:0] resAddr,
  output logic [CNT_W-1:0]  resCount,
  output logic [WARN_W-1:0] resWarn
);

  localparam int HALF     = ADDR_W / 2;
  localparam int PG_SHIFT = $clog2(PAGE_SIZE);

  logic [ADDR_W-1:0] wordAddr, addrCtr, lastAddr, stepAddr, nextCtr;
  logic [WARN_W-1:0] pageWarn;
  logic              isCur;

  assign isCur    = (strb.cls == CL_CUR_RD);
  assign lastAddr = wordAddr + ADDR_W'(dataCnt) - ADDR_W'(1);
  assign stepAddr = isCur ? (addrCtr + ADDR_W'(1)) : (wordAddr + ADDR_W'(dataCnt));
  assign nextCtr  = cfgTwoByteAddr ? stepAddr : {{(ADDR_W-HALF){1'b0}}, stepAddr[HALF-1:0]};

  always_comb begin
    pageWarn = '0;
    if (strb.cls == CL_PAGE_WR) begin
      pageWarn[WB_OVER]  = (32'(dataCnt) > PAGE_SIZE);
      pageWarn[WB_CROSS] = ((wordAddr >> PG_SHIFT) != (lastAddr >> PG_SHIFT));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wordAddr <= '0;
      dataCnt  <= '0;
      addrCtr  <= cfgInitAddr;
      resValid <= 1'b0;
      resClass <= '0;
      resAddr  <= '0;
      resCount <= '0;
      resWarn  <= '0;
    end else begin
      resValid <= strb.emit;
      if (strb.emit) begin
        resClass <= strb.cls;
        resAddr  <= isCur ? addrCtr : wordAddr;
        resCount <= dataCnt;
        resWarn  <= strb.warn | pageWarn;
        if (strb.cls != CL_NONE) addrCtr <= nextCtr;
      end
      if (strb.clear) begin
        wordAddr <= '0;
        dataCnt  <= '0;
      end else begin
        if (strb.ldHi) wordAddr[ADDR_W-1:HALF] <= evtData;
        if (strb.ldLo) wordAddr[HALF-1:0]      <= evtData;
        if (strb.incCnt && dataCnt != '1) dataCnt <= dataCnt + 1'b1;
      end
    end
  end

  // R13
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resValid |=> !resValid);

  // R3
  byte_write_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resValid && resClass == CL_BYTE_WR) |-> (resCount == CNT_W'(1)));

  // R9
  page_warn_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resValid && resClass != CL_PAGE_WR) |-> (resWarn[WB_CROSS:WB_OVER] == 2'b00));

  // R10
  abort_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resValid && resClass == CL_NONE) |-> (resWarn[WB_ABORT:WB_NOREPLY] != 2'b00));

  // R6
  cur_read_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resValid && resClass == CL_CUR_RD && cfgTwoByteAddr) |-> (addrCtr == resAddr + ADDR_W'(1)));

endmodule

// File: rtl/eeprom_op_sorter.sv
module eeprom_op_sorter
  import eos_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int CNT_W     = 8,
  parameter int PAGE_SIZE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evtValid,
  input  logic [3:0]        evtKind,
  input  logic [7:0]        evtData,
  input  logic              cfgTwoByteAddr,
  input  logic [ADDR_W-1:0] cfgInitAddr,
  output logic              resValid,
  output logic [2:0]        resClass,
  output logic [ADDR_W-1:0] resAddr,
  output logic [CNT_W-1:0]  resCount,
  output logic [WARN_W-1:0] resWarn
);

  strobe_t          strb;
  logic [CNT_W-1:0] dataCnt;

  eos_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .evtValid       (evtValid),
    .evtKind        (evtKind),
    .cfgTwoByteAddr (cfgTwoByteAddr),
    .dataCnt        (dataCnt),
    .strb           (strb)
  );

  eos_datapath #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .PAGE_SIZE(PAGE_SIZE)) u_dp (
    .clk            (clk),
    .rst_n          (rst_n),
    .strb           (strb),
    .evtData        (evtData),
    .cfgTwoByteAddr (cfgTwoByteAddr),
    .cfgInitAddr    (cfgInitAddr),
    .dataCnt        (dataCnt),
    .resValid       (resValid),
    .resClass       (resClass),
    .resAddr        (resAddr),
    .resCount       (resCount),
    .resWarn        (resWarn)
  );

endmodule

// File: tb/sim_eeprom_op_sorter.sv
module sim_eeprom_op_sorter;
  import eos_pkg::*;

  localparam int PG = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        evtValid = 1'b0;
  logic [3:0]  evtKind = 4'd0;
  logic [7:0]  evtData = 8'd0;
  logic        cfgTwoByteAddr = 1'b1;
  logic [15:0] cfgInitAddr = 16'h0123;
  logic        resValid;
  logic [2:0]  resClass;
  logic [15:0] resAddr;
  logic [7:0]  resCount;
  logic [5:0]  resWarn;

  int tests = 0;
  int fails = 0;
  int gotN;
  int gotCls, gotAddr, gotCnt, gotWarn;
  int mdl;

  eeprom_op_sorter #(.PAGE_SIZE(PG)) u0 (
    .clk(clk), .rst_n(rst_n), .evtValid(evtValid), .evtKind(evtKind),
    .evtData(evtData), .cfgTwoByteAddr(cfgTwoByteAddr), .cfgInitAddr(cfgInitAddr),
    .resValid(resValid), .resClass(resClass), .resAddr(resAddr),
    .resCount(resCount), .resWarn(resWarn)
  );

  always #4 clk = ~clk;

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ev(evt_e k, logic [7:0] d);
    @(negedge clk);
    evtValid = 1'b1; evtKind = k; evtData = d;
    @(posedge clk); #1;
    evtValid = 1'b0;
    if (resValid) begin
      gotN++;
      gotCls = int'(resClass); gotAddr = int'(resAddr);
      gotCnt = int'(resCount); gotWarn = int'(resWarn);
    end
  endtask

  task automatic expectRes(string req, int cls, int addr, int cnt, int warn);
    chk({req, " pulses"}, gotN, 1);
    chk({req, " class"}, gotCls, cls);
    chk({req, " addr"}, gotAddr, addr);
    chk({req, " count"}, gotCnt, cnt);
    chk({req, " warn"}, gotWarn, warn);
  endtask

  function automatic int maskAddr(int a);
    return cfgTwoByteAddr ? (a & 16'hFFFF) : (a & 8'hFF);
  endfunction

  task automatic sendAddr(int addr);
    if (cfgTwoByteAddr) begin
      ev(EV_DATA_WR, addr[15:8]); ev(EV_ACK, 8'h00);
    end
    ev(EV_DATA_WR, addr[7:0]); ev(EV_ACK, 8'h00);
  endtask

  task automatic doCur(string req);
    gotN = 0;
    ev(EV_START, 0); ev(EV_ADDR_RD, 8'hA1); ev(EV_ACK, 0);
    ev(EV_DATA_RD, 8'h5A); ev(EV_NACK, 0); ev(EV_STOP, 0);
    expectRes(req, 3, mdl, 1, 0);
    mdl = maskAddr(mdl + 1);
  endtask

  task automatic doWrite(int addr, int n);
    int warn;
    gotN = 0;
    ev(EV_START, 0); ev(EV_ADDR_WR, 8'hA0); ev(EV_ACK, 0);
    sendAddr(addr);
    for (int i = 0; i < n; i++) begin
      ev(EV_DATA_WR, 8'(i)); ev(EV_ACK, 0);
    end
    ev(EV_STOP, 0);
    if (n == 0) begin
      chk("R4 no result without data", gotN, 0);
    end else if (n == 1) begin
      expectRes("R3 byte write", 1, addr, 1, 0);
      mdl = maskAddr(addr + n);
    end else begin
      warn = 0;
      if (n > PG) warn |= 4;                                    // R8
      if ((addr >> 4) != (((addr + n - 1) & 16'hFFFF) >> 4)) warn |= 8; // R9
      expectRes("R4 R8 R9 page write", 2, addr, n, warn);
      mdl = maskAddr(addr + n);
    end
  endtask

  task automatic doRand(int addr, int n, bit ackLast);
    gotN = 0;
    ev(EV_START, 0); ev(EV_ADDR_WR, 8'hA0); ev(EV_ACK, 0);
    sendAddr(addr);
    ev(EV_RESTART, 0); ev(EV_ADDR_RD, 8'hA1); ev(EV_ACK, 0);
    for (int i = 0; i < n; i++) begin
      ev(EV_DATA_RD, 8'(i + 3));
      if (i == n - 1 && !ackLast) ev(EV_NACK, 0);
      else                        ev(EV_ACK, 0);
    end
    ev(EV_STOP, 0);
    if (ackLast) expectRes("R11 stop after ACKed read", (n == 1) ? 4 : 5, addr, n, 16);
    else         expectRes("R5 random read", (n == 1) ? 4 : 5, addr, n, 0);
    mdl = maskAddr(addr + n);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    int lows[3];
    lows[0] = 8'h00; lows[1] = 8'h0E; lows[2] = 8'hF5;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 resValid in reset", int'(resValid), 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 resValid after reset", int'(resValid), 0);
    mdl = 16'h0123;
    doCur("R1 R6 counter from init");
    doCur("R6 counter advanced");

    // R2: non-address event after start, events before any start
    gotN = 0;
    ev(EV_START, 0); ev(EV_DATA_WR, 8'h55); ev(EV_ACK, 0); ev(EV_STOP, 0);
    ev(EV_ADDR_WR, 8'hA0); ev(EV_ACK, 0); ev(EV_DATA_WR, 8'h10); ev(EV_ACK, 0);
    ev(EV_DATA_WR, 8'h11); ev(EV_ACK, 0); ev(EV_STOP, 0);
    chk("R2 ignored events give no result", gotN, 0);
    doCur("R2 counter untouched");

    // R3 R4 R7 R8 R9 sweep over modes, bases and counts
    for (int m = 0; m < 2; m++) begin
      cfgTwoByteAddr = m[0];
      for (int b = 0; b < 3; b++) begin
        for (int n = 0; n <= PG + 2; n++) begin
          int a;
          a = m ? (16'h3A00 | lows[b]) : lows[b];
          doWrite(a, n);
          doCur("R7 counter after write");
        end
      end
    end

    // R13 no second pulse
    doWrite(16'h0040, 1);
    @(posedge clk); #1;
    chk("R13 pulse width", int'(resValid), 0);

    // R5 R7 random reads, both modes
    for (int m = 0; m < 2; m++) begin
      cfgTwoByteAddr = m[0];
      for (int n = 1; n <= 5; n++) begin
        doRand(m ? 16'h7FFE : 16'h00FE, n, 1'b0);
        doCur("R7 counter after random read");
      end
    end
    cfgTwoByteAddr = 1'b1;

    // R11
    doRand(16'h0200, 2, 1'b1);
    doRand(16'h0300, 1, 1'b1);

    // R10 aborts
    gotN = 0;
    ev(EV_START, 0); ev(EV_ADDR_WR, 8'hA0); ev(EV_NACK, 0);
    expectRes("R10 control NACK", 0, 0, 0, 1);
    gotN = 0;
    ev(EV_START, 0); ev(EV_ADDR_RD, 8'hA1); ev(EV_ACK, 0); ev(EV_STOP, 0);
    expectRes("R10 read stop after control", 0, 0, 0, 2);
    gotN = 0;
    ev(EV_START, 0); ev(EV_ADDR_WR, 8'hA0); ev(EV_ACK, 0); ev(EV_STOP, 0);
    expectRes("R10 write stop after control", 0, 0, 0, 2);
    doCur("R10 counter unmoved");

    // R12 restart in place of stop, then new control phase at once
    gotN = 0;
    ev(EV_START, 0); ev(EV_ADDR_RD, 8'hA1); ev(EV_ACK, 0);
    ev(EV_DATA_RD, 8'h77); ev(EV_NACK, 0); ev(EV_RESTART, 0);
    expectRes("R12 report on restart", 3, mdl, 1, 32);
    mdl = maskAddr(mdl + 1);
    gotN = 0;
    ev(EV_ADDR_WR, 8'hA0); ev(EV_ACK, 0);
    sendAddr(16'h1234);
    ev(EV_DATA_WR, 8'h99); ev(EV_ACK, 0); ev(EV_STOP, 0);
    expectRes("R12 follow-on byte write", 1, 16'h1234, 1, 0);
    mdl = 16'h1235;
    doCur("R12 counter after follow-on");

    summary();
    $finish;
  end

endmodule